// File: doc/BRIEF.md
# Addend-Rate Precision Time Counter

This block keeps a 64-bit count of system time for a packet timestamping assist. A 32-bit fractional accumulator sets the tick rate. On every clock the accumulator adds a programmable addend, and each carry out of that addition advances the time count by one. Changing the addend trims the clock frequency in fine steps. Each count stands for 32 ns, and the block also presents the time in nanoseconds.

Software uses a small 32-bit register bus to program the rate, read and load the time, and set a target time. The 64-bit time and target values are moved as two words in a fixed order. Reading the low word freezes the matching high word. Writing the low word only stages it until the high word arrives. A comparator raises a sticky pending flag when the count reaches the target. A control bit holds the whole block in soft reset.

After reset the counter wraps within its low 32 bits. Software switches it to full 64-bit counting by arming an enable register and then writing an all-ones value.

Top module: `tick_time_counter`

## Requirements
- R1: After the reset input is low, the addend reads 0xA0000000, the time count is 0, the pending flag is 0, both target words read 0xFFFFFFFF, and the counter is in narrow (32-bit) mode, so the full-width register reads 0.
- R2: On every clock the accumulator adds the addend modulo 2^32. The time count rises by exactly one in each cycle where that addition carries out and is unchanged otherwise. An addend of 0 stops the count.
- R3: The nanosecond output always equals the time count shifted left by 5.
- R4: A read of the time low word (address 4) returns bits 31:0 and copies bits 63:32 into a shadow. A following read of the time high word (address 5) returns that shadow, even if the live count has carried into its high half since.
- R5: A write to the time low word is only staged and leaves the count unchanged. A later write to the high word loads both halves into the count at once.
- R6: A time load takes effect in its own cycle in place of any increment. The count afterwards equals the written value exactly.
- R7: In narrow mode bits 63:32 of the count never change by counting, and the low half wraps to 0. Writing 0xFFFFFFFF to address 9 while address 8 holds 1 selects full 64-bit counting, and address 9 then reads 0xFFFFFFFF. The same write with address 8 at 0, or a different value, selects or keeps narrow mode.
- R8: The target is written as low word (address 6, staged) then high word (address 7, commits both). When the count equals the target, the pending output and bit 1 of the event register (address 1) become 1 on the next clock and stay 1.
- R9: Writing the event register with bit 1 set clears the pending flag. Writing it with bit 1 clear has no effect.
- R10: While control bit 0 (address 0) is 1, every other register and the count are held at their R1 values and bus writes to them are ignored. The control bit reads back, and clearing it lets counting resume.
- R11: The addend (address 2) and accumulator (address 3) are writable and read back. An accumulator write replaces that cycle's addition.
- R12: Read data appears one clock after the read strobe and holds until the next read. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the accumulator steps on every rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| time_now | output | 64 | Live time count |
| time_ns | output | 64 | Live time in nanoseconds |
| target_pend | output | 1 | Target-reached pending flag |

## Verification
Several properties are checked on every cycle by the assertions. The count stays still when there is neither a carry nor a load, and a load always wins over an increment. The upper half is frozen in narrow mode. A zero addend freezes the accumulator. The pending flag sets on a match and only falls through a clear or a reset. The shadow capture and the addend write path are also checked each cycle. Only the bench's scenarios can show the things that span many cycles:

- the tick ratio for a given addend over a measured window;
- the word ordering of time reads against a carry into the high half;
- the narrow-mode wrap against full-mode carry;
- the full soft-reset sequence as seen through bus reads.

// File: rtl/tcnt_pkg.sv
// Shared register addresses and field positions for the time counter.
package tcnt_pkg;
    localparam int REG_AW        = 4;
    localparam int CTRL_SRST_BIT = 0;
    localparam int EVT_PEND_BIT  = 1;

    typedef enum logic [REG_AW-1:0] {
        RA_CTRL     = 4'd0,
        RA_EVENT    = 4'd1,
        RA_ADDEND   = 4'd2,
        RA_ACCUM    = 4'd3,
        RA_TIME_LO  = 4'd4,
        RA_TIME_HI  = 4'd5,
        RA_TGT_LO   = 4'd6,
        RA_TGT_HI   = 4'd7,
        RA_WIDE_EN  = 4'd8,
        RA_WIDE_VAL = 4'd9
    } reg_addr_e;
endpackage

// File: rtl/tcnt_rate_accum.sv
// Fractional rate accumulator.
// What it does: adds the addend into an ACC_W-bit accumulator every clock and
//   flags a tick whenever that sum carries out of the top bit.
// Assumes: clr (soft reset) and ld (bus write) are single-domain synchronous
//   controls; a load replaces the addition in its cycle and yields no tick.
module tcnt_rate_accum #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [ACC_W-1:0] addend,
    input  logic             ld,
    input  logic [ACC_W-1:0] ld_val,
    output logic [ACC_W-1:0] acc,
    output logic             tick
);
    logic [ACC_W:0]   sum;
    logic [ACC_W-1:0] acc_q;

    // Purpose: form the widened sum so its top bit is the carry.
    always_comb begin
        sum  = {1'b0, acc_q} + {1'b0, addend};
        tick = sum[ACC_W] & ~ld & ~clr;
    end

    // Purpose: step, load or clear the accumulator.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) acc_q <= '0;
        else if (ld)       acc_q <= ld_val;
        else               acc_q <= sum[ACC_W-1:0];
    end

    assign acc = acc_q;

    // R11: a bus load replaces the addition
    a_r11_acc_load: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && !clr) |=> (acc_q == $past(ld_val)));
    // R2: a zero addend freezes the accumulator
    a_r2_zero_addend_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && !clr && addend == '0) |=> $stable(acc_q));
    // R2: no tick can come from a zero addend
    a_r2_tick_needs_addend: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (addend != '0));
endmodule

// File: rtl/tcnt_time_core.sv
// Time count register.
// What it does: holds the TIME_W-bit count, adds one per tick, loads a full
//   value on request (load beats tick), and in narrow mode confines counting
//   to the low NARROW_W bits.
// Assumes: tick and ld are one-cycle pulses from the same clock domain.
module tcnt_time_core #(
    parameter int TIME_W   = 64,
    parameter int NARROW_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              tick,
    input  logic              wide,
    input  logic              ld,
    input  logic [TIME_W-1:0] ld_val,
    output logic [TIME_W-1:0] cnt
);
    logic [TIME_W-1:0] cnt_q;
    logic [TIME_W-1:0] cnt_inc;

    // Purpose: pick the incremented value for the configured width variant.
    generate
        if (NARROW_W < TIME_W) begin : g_split
            always_comb begin
                if (wide) cnt_inc = cnt_q + TIME_W'(1);
                else      cnt_inc = {cnt_q[TIME_W-1:NARROW_W],
                                     cnt_q[NARROW_W-1:0] + NARROW_W'(1)};
            end
            // R7: narrow mode never carries into the upper part
            a_r7_narrow_upper_frozen: assert property (@(posedge clk) disable iff (!rst_n)
                (!ld && !clr && !wide) |=> (cnt_q[TIME_W-1:NARROW_W] == $past(cnt_q[TIME_W-1:NARROW_W])));
        end else begin : g_flat
            always_comb cnt_inc = cnt_q + TIME_W'(1);
        end
    endgenerate

    // Purpose: clear, load or advance the count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt_q <= '0;
        else if (ld)       cnt_q <= ld_val;
        else if (tick)     cnt_q <= cnt_inc;
    end

    assign cnt = cnt_q;

    // R6: a load lands exactly, with no increment on top
    a_r6_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && !clr) |=> (cnt_q == $past(ld_val)));
    // R2: without a carry or load the count holds
    a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && !tick && !clr) |=> $stable(cnt_q));
    // R10: soft reset zeroes the count
    a_r10_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));
endmodule

// File: rtl/tcnt_target_cmp.sv
// Target comparator.
// What it does: compares the live count with the target and keeps a sticky
//   pending flag that is set on equality and cleared by an acknowledge.
// Assumes: set has priority over acknowledge in the same cycle.
module tcnt_target_cmp #(
    parameter int TIME_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [TIME_W-1:0] cnt,
    input  logic [TIME_W-1:0] target,
    input  logic              ack,
    output logic              pend
);
    logic hit;
    logic pend_q;

    // Purpose: detect that the count has reached the target.
    always_comb hit = (cnt == target);

    // Purpose: hold the pending flag until acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) pend_q <= 1'b0;
        else if (hit)      pend_q <= 1'b1;
        else if (ack)      pend_q <= 1'b0;
    end

    assign pend = pend_q;

    // R8: a match always raises the flag on the next clock
    a_r8_match_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !clr) |=> pend_q);
    // R9: the flag only falls through an acknowledge or a reset
    a_r9_fall_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pend_q) |-> $past(ack || clr || !rst_n));
endmodule

// File: rtl/tcnt_regbank.sv
// Register bank for the time counter.
// What it does: decodes the word-addressed bus, holds addend, target,
//   control and width-mode state, stages the low halves of 64-bit writes,
//   keeps the high-half read shadow and registers the read data.
// Assumes: TIME_W is twice DATA_W and ACC_W is no wider than DATA_W; the
//   control register is cleared only by the reset input.
module tcnt_regbank
    import tcnt_pkg::*;
#(
    parameter int              DATA_W     = 32,
    parameter int              TIME_W     = 64,
    parameter int              ACC_W      = 32,
    parameter logic [ACC_W-1:0] DEF_ADDEND = 32'hA000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [TIME_W-1:0] cnt,
    input  logic [ACC_W-1:0]  acc,
    input  logic              pend,
    output logic              srst,
    output logic [ACC_W-1:0]  addend,
    output logic              acc_ld,
    output logic [ACC_W-1:0]  acc_ld_val,
    output logic              time_ld,
    output logic [TIME_W-1:0] time_ld_val,
    output logic [TIME_W-1:0] target,
    output logic              wide,
    output logic              evt_ack
);
    localparam int HI_W = TIME_W - DATA_W;

    logic              ctrl_q;
    logic              blk_rst;
    logic              wr_ok;
    logic [ACC_W-1:0]  addend_q;
    logic [DATA_W-1:0] time_stage_q;
    logic [DATA_W-1:0] tgt_stage_q;
    logic [TIME_W-1:0] target_q;
    logic              wide_en_q;
    logic              wide_q;
    logic [HI_W-1:0]   shadow_q;
    logic [DATA_W-1:0] rdata_q;
    logic [DATA_W-1:0] rd_word;

    // Purpose: gate writes and derive the block-wide reset.
    always_comb begin
        blk_rst = !rst_n || ctrl_q;
        wr_ok   = bus_wr && !ctrl_q;
    end

    // Purpose: control register; only the reset input clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= 1'b0;
        else if (bus_wr && bus_addr == RA_CTRL) ctrl_q <= bus_wdata[CTRL_SRST_BIT];
    end

    // Purpose: addend, staging, target and width-mode registers.
    always_ff @(posedge clk) begin
        if (blk_rst) begin
            addend_q     <= DEF_ADDEND;
            time_stage_q <= '0;
            tgt_stage_q  <= '0;
            target_q     <= '1;
            wide_en_q    <= 1'b0;
            wide_q       <= 1'b0;
        end else if (wr_ok) begin
            case (bus_addr)
                RA_ADDEND:   addend_q     <= bus_wdata[ACC_W-1:0];
                RA_TIME_LO:  time_stage_q <= bus_wdata;
                RA_TGT_LO:   tgt_stage_q  <= bus_wdata;
                RA_TGT_HI:   target_q     <= {bus_wdata[HI_W-1:0], tgt_stage_q};
                RA_WIDE_EN:  wide_en_q    <= bus_wdata[0];
                RA_WIDE_VAL: wide_q       <= wide_en_q && (bus_wdata == '1);
                default: ;
            endcase
        end
    end

    // Purpose: single-cycle load and acknowledge pulses to the datapath.
    always_comb begin
        acc_ld      = wr_ok && (bus_addr == RA_ACCUM);
        acc_ld_val  = bus_wdata[ACC_W-1:0];
        time_ld     = wr_ok && (bus_addr == RA_TIME_HI);
        time_ld_val = {bus_wdata[HI_W-1:0], time_stage_q};
        evt_ack     = wr_ok && (bus_addr == RA_EVENT) && bus_wdata[EVT_PEND_BIT];
    end

    // Purpose: read multiplexer over all mapped words.
    always_comb begin
        rd_word = '0;
        case (bus_addr)
            RA_CTRL:     rd_word[CTRL_SRST_BIT] = ctrl_q;
            RA_EVENT:    rd_word[EVT_PEND_BIT]  = pend;
            RA_ADDEND:   rd_word = DATA_W'(addend_q);
            RA_ACCUM:    rd_word = DATA_W'(acc);
            RA_TIME_LO:  rd_word = cnt[DATA_W-1:0];
            RA_TIME_HI:  rd_word = DATA_W'(shadow_q);
            RA_TGT_LO:   rd_word = target_q[DATA_W-1:0];
            RA_TGT_HI:   rd_word = DATA_W'(target_q[TIME_W-1:DATA_W]);
            RA_WIDE_EN:  rd_word[0] = wide_en_q;
            RA_WIDE_VAL: rd_word = {DATA_W{wide_q}};
            default:     rd_word = '0;
        endcase
    end

    // Purpose: capture the high half when the low time word is read.
    always_ff @(posedge clk) begin
        if (blk_rst) shadow_q <= '0;
        else if (bus_rd && bus_addr == RA_TIME_LO) shadow_q <= cnt[TIME_W-1:DATA_W];
    end

    // Purpose: register read data; it holds between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (bus_rd) rdata_q <= rd_word;
    end

    assign srst      = ctrl_q;
    assign addend    = addend_q;
    assign target    = target_q;
    assign wide      = wide_q;
    assign bus_rdata = rdata_q;

    // R11: an accepted addend write is stored as written
    a_r11_addend_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == RA_ADDEND && !ctrl_q) |=> (addend_q == $past(bus_wdata[ACC_W-1:0])));
    // R10: soft reset restores the default addend
    a_r10_srst_addend: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q |=> (addend_q == DEF_ADDEND));
    // R4: a low-word read snapshots the high half of the count
    a_r4_shadow_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == RA_TIME_LO && !ctrl_q) |=> (shadow_q == $past(cnt[TIME_W-1:DATA_W])));
    // R12: read data holds while no read is issued
    a_r12_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(rdata_q));
endmodule

// File: rtl/tick_time_counter.sv
// Addend-rate precision time counter (top).
// What it does: ties the register bank, the fractional rate accumulator,
//   the time count and the target comparator together and exposes the live
//   count, its nanosecond form and the pending flag.
// Assumes: one clock domain; NS_SHIFT converts counts to nanoseconds.
module tick_time_counter #(
    parameter int              DATA_W     = 32,
    parameter int              TIME_W     = 64,
    parameter int              ACC_W      = 32,
    parameter int              NARROW_W   = 32,
    parameter int              NS_SHIFT   = 5,
    parameter logic [ACC_W-1:0] DEF_ADDEND = 32'hA000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [3:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [TIME_W-1:0] time_now,
    output logic [TIME_W-1:0] time_ns,
    output logic              target_pend
);
    logic              srst;
    logic [ACC_W-1:0]  addend;
    logic              acc_ld;
    logic [ACC_W-1:0]  acc_ld_val;
    logic [ACC_W-1:0]  acc;
    logic              tick;
    logic              time_ld;
    logic [TIME_W-1:0] time_ld_val;
    logic [TIME_W-1:0] target;
    logic              wide;
    logic              evt_ack;
    logic              pend;
    logic [TIME_W-1:0] cnt;

    tcnt_regbank #(
        .DATA_W(DATA_W), .TIME_W(TIME_W), .ACC_W(ACC_W), .DEF_ADDEND(DEF_ADDEND)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cnt(cnt), .acc(acc), .pend(pend),
        .srst(srst), .addend(addend),
        .acc_ld(acc_ld), .acc_ld_val(acc_ld_val),
        .time_ld(time_ld), .time_ld_val(time_ld_val),
        .target(target), .wide(wide), .evt_ack(evt_ack)
    );

    tcnt_rate_accum #(.ACC_W(ACC_W)) u_accum (
        .clk(clk), .rst_n(rst_n), .clr(srst),
        .addend(addend), .ld(acc_ld), .ld_val(acc_ld_val),
        .acc(acc), .tick(tick)
    );

    tcnt_time_core #(.TIME_W(TIME_W), .NARROW_W(NARROW_W)) u_time (
        .clk(clk), .rst_n(rst_n), .clr(srst),
        .tick(tick), .wide(wide),
        .ld(time_ld), .ld_val(time_ld_val), .cnt(cnt)
    );

    tcnt_target_cmp #(.TIME_W(TIME_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .clr(srst),
        .cnt(cnt), .target(target), .ack(evt_ack), .pend(pend)
    );

    // Purpose: present the count in counts and in nanoseconds.
    always_comb begin
        time_now    = cnt;
        time_ns     = cnt << NS_SHIFT;
        target_pend = pend;
    end
endmodule

// File: tb/sim_tick_time_counter.sv
module sim_tick_time_counter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] time_now;
    logic [63:0] time_ns;
    logic        target_pend;

    int n_chk = 0;
    int n_bad = 0;

    localparam logic [3:0] A_CTRL = 4'd0, A_EVT = 4'd1, A_ADD = 4'd2, A_ACC = 4'd3,
                           A_TLO = 4'd4, A_THI = 4'd5, A_GLO = 4'd6, A_GHI = 4'd7,
                           A_WEN = 4'd8, A_WVAL = 4'd9;

    tick_time_counter u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .time_now(time_now), .time_ns(time_ns), .target_pend(target_pend)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // All bus tasks start and end on a falling edge.
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic load_time(input logic [31:0] hi, input logic [31:0] lo);
        wr(A_TLO, lo);
        wr(A_THI, hi);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset_state();
        logic [31:0] d;
        check("R1 time during reset", time_now, 64'd0);
        check("R1 pending during reset", {63'd0, target_pend}, 64'd0);
        rst_n = 1'b1;
        rd(A_ADD, d);  check("R1 addend default", {32'd0, d}, 64'hA000_0000);
        rd(A_GHI, d);  check("R1 target hi", {32'd0, d}, 64'hFFFF_FFFF);
        rd(A_GLO, d);  check("R1 target lo", {32'd0, d}, 64'hFFFF_FFFF);
        rd(A_WVAL, d); check("R1 narrow mode", {32'd0, d}, 64'd0);
        rd(4'hF, d);   check("R12 unmapped reads 0", {32'd0, d}, 64'd0);
        idle(3);
        check("R12 rdata holds", {32'd0, bus_rdata}, 64'd0);
    endtask

    // R2: one tick per accumulator carry, measured over n clocks
    task automatic rate_case(input logic [31:0] add, input int n, input logic [31:0] exp);
        logic [31:0] d;
        wr(A_ADD, 32'd0);
        wr(A_ACC, 32'd0);
        load_time(32'd0, 32'd0);
        wr(A_ADD, add);
        idle(n);
        rd(A_TLO, d);
        check("R2 ticks per carry", {32'd0, d}, {32'd0, exp});
    endtask

    task automatic t_ns_and_stage();
        wr(A_ADD, 32'd0);
        load_time(32'h1, 32'h3);
        check("R3 ns output", time_ns, 64'h20_0000_0060);
        load_time(32'h0, 32'h100);
        wr(A_TLO, 32'h555);
        check("R5 low write staged", time_now, 64'h100);
        wr(A_THI, 32'h9);
        check("R5 both halves load", time_now, 64'h9_0000_0555);
    endtask

    task automatic t_priority_narrow_wide();
        logic [31:0] d;
        wr(A_ADD, 32'd0);
        wr(A_ACC, 32'hFFFF_FFFF);
        wr(A_ADD, 32'hFFFF_FFFF);          // now one tick every clock
        load_time(32'h2, 32'h1234);
        check("R6 load beats increment", time_now, 64'h2_0000_1234);
        idle(3);
        check("R6 counting after load", time_now, 64'h2_0000_1237);
        load_time(32'h5, 32'hFFFF_FFFE);
        idle(4);
        check("R7 narrow wraps low half", time_now, 64'h5_0000_0002);
        wr(A_WVAL, 32'hFFFF_FFFF);         // enable still 0: ignored
        rd(A_WVAL, d); check("R7 value without enable", {32'd0, d}, 64'd0);
        wr(A_WEN, 32'd1);
        wr(A_WVAL, 32'h1234);
        rd(A_WVAL, d); check("R7 wrong value stays narrow", {32'd0, d}, 64'd0);
        wr(A_WVAL, 32'hFFFF_FFFF);
        rd(A_WVAL, d); check("R7 full mode selected", {32'd0, d}, 64'hFFFF_FFFF);
        load_time(32'h5, 32'hFFFF_FFFE);
        idle(4);
        check("R7 full mode carries", time_now, 64'h6_0000_0002);
    endtask

    task automatic t_read_order();
        logic [31:0] d;
        load_time(32'h7, 32'hFFFF_FFFB);
        rd(A_TLO, d);
        check("R4 low word", {32'd0, d}, 64'hFFFF_FFFB);
        idle(10);
        check("R4 live high moved on", {32'd0, time_now[63:32]}, 64'h8);
        rd(A_THI, d);
        check("R4 high from shadow", {32'd0, d}, 64'h7);
    endtask

    task automatic t_target();
        logic [31:0] d;
        wr(A_GLO, 32'd50);
        rd(A_GLO, d); check("R8 target low staged", {32'd0, d}, 64'hFFFF_FFFF);
        wr(A_GHI, 32'd0);
        rd(A_GLO, d); check("R8 target committed", {32'd0, d}, 64'd50);
        load_time(32'h0, 32'd30);
        idle(10);
        check("R8 not yet reached", {63'd0, target_pend}, 64'd0);
        idle(15);
        check("R8 pending raised", {63'd0, target_pend}, 64'd1);
        rd(A_EVT, d); check("R8 event bit 1", {32'd0, d}, 64'h2);
        wr(A_EVT, 32'h0);
        check("R9 zero write no effect", {63'd0, target_pend}, 64'd1);
        wr(A_EVT, 32'h2);
        check("R9 ack clears", {63'd0, target_pend}, 64'd0);
    endtask

    task automatic t_soft_reset();
        logic [31:0] d;
        wr(A_CTRL, 32'd1);
        rd(A_CTRL, d); check("R10 control reads back", {32'd0, d}, 64'd1);
        wr(A_ADD, 32'h1);                 // ignored while held
        rd(A_ADD, d);  check("R10 addend default held", {32'd0, d}, 64'hA000_0000);
        rd(A_WVAL, d); check("R10 narrow mode restored", {32'd0, d}, 64'd0);
        idle(5);
        check("R10 time held at zero", time_now, 64'd0);
        check("R10 pending cleared", {63'd0, target_pend}, 64'd0);
        wr(A_CTRL, 32'd0);
        idle(20);
        check("R10 counting resumes", {63'd0, (time_now != 64'd0)}, 64'd1);
    endtask

    task automatic t_accum();
        logic [31:0] d;
        wr(A_ADD, 32'd0);
        wr(A_ACC, 32'h1234_5678);
        rd(A_ACC, d); check("R11 accumulator readback", {32'd0, d}, 64'h1234_5678);
        wr(A_ADD, 32'h1000);
        rd(A_ADD, d); check("R11 addend readback", {32'd0, d}, 64'h1000);
        wr(A_ACC, 32'hABCD);
        rd(A_ACC, d); check("R11 load replaces add", {32'd0, d}, 64'hABCD);
    endtask

    initial begin
        idle(4);
        t_reset_state();
        rate_case(32'h8000_0000, 10, 32'd5);
        rate_case(32'h4000_0000, 12, 32'd3);
        rate_case(32'h0000_0000, 10, 32'd0);
        rate_case(32'hFFFF_FFFF, 10, 32'd9);
        rate_case(32'hA000_0000, 16, 32'd10);
        t_ns_and_stage();
        t_priority_narrow_wide();
        t_read_order();
        t_target();
        t_soft_reset();
        t_accum();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule